// File: doc/BRIEF.md
# Push-Button Up/Down Counter

This block keeps a small binary count that two active-low push buttons step up and down. Both buttons are treated as ordinary asynchronous data inputs. Each one is resampled on the system clock through a two-stage synchroniser. A press is detected when the synchronised level is 0 and the level registered on the previous cycle was 1. That produces a strobe lasting one clock cycle, and the strobe moves the counter by one.

The count register is clocked only by the system clock. Neither button ever clocks it or resets it asynchronously. The block drives the count directly and also drives an active-low seven-segment pattern for one hexadecimal digit. It sits between raw board buttons and a single display digit, and it expects contact bounce to have been removed upstream.

Top module: `updown_key_counter`

## Requirements
- R1: While the synchronous active-low reset `rstN` is 0 at a rising clock edge, the count becomes 0 and `segN` shows digit 0 (7'h40). With both keys held at 1 through reset, no step follows the release of reset.
- R2: A falling edge on `incKeyN` on its own raises the count by one.
- R3: A falling edge on `decKeyN` on its own lowers the count by one.
- R4: The count wraps modulo 2^WIDTH in both directions. With the default WIDTH of 4, 15 plus one gives 0 and 0 minus one gives 15.
- R5: Holding a key low for any number of cycles steps the count exactly once. Releasing a key (0 to 1) leaves the count unchanged.
- R6: When both keys produce a press in the same clock cycle, the count is unchanged.
- R7: Each key passes through two synchroniser flops before edge detection. If a key falls before rising edge N, the count still holds its old value after edge N+1 and holds the new value after edge N+2.
- R8: `segN` is active low with bit 6 = g down to bit 0 = a. For count values 0 to F it equals the bitwise inverse of 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex).
- R9: Each internal press strobe stays high for exactly one clock cycle per falling edge. The count changes only in a cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register uses its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| incKeyN | input | 1 | Increment button, active low, asynchronous |
| decKeyN | input | 1 | Decrement button, active low, asynchronous |
| count | output | WIDTH (4) | Current count |
| segN | output | 7 | Active-low segments, bit 6 = g, bit 0 = a |

## Verification
On every cycle, the bound checker confirms four things: an increment strobe alone raises the count by one with wraparound, a decrement strobe alone lowers it, simultaneous or absent strobes hold it, and every strobe drops after a single cycle. The effect of reset on the count is checked the same way. Other behaviour is visible only from the bench's key sequences: the two-cycle synchroniser delay, the single step for a long hold, the lack of any step on release, and the full segment table. The bench measures each of these against its own model of key levels.

// File: rtl/updown_key_pkg.sv
package updown_key_pkg;

  // Strobes passed from the control section to the datapath
  typedef struct packed {
    logic incStb;
    logic decStb;
  } ctrlStrobes_t;

  // Hex nibble to active-low segment pattern, bit 6 = g ... bit 0 = a
  function automatic logic [6:0] hexToSegN(input logic [3:0] nib);
    logic [6:0] segOn;
    case (nib)
      4'h0: segOn = 7'h3F;
      4'h1: segOn = 7'h06;
      4'h2: segOn = 7'h5B;
      4'h3: segOn = 7'h4F;
      4'h4: segOn = 7'h66;
      4'h5: segOn = 7'h6D;
      4'h6: segOn = 7'h7D;
      4'h7: segOn = 7'h07;
      4'h8: segOn = 7'h7F;
      4'h9: segOn = 7'h6F;
      4'hA: segOn = 7'h77;
      4'hB: segOn = 7'h7C;
      4'hC: segOn = 7'h39;
      4'hD: segOn = 7'h5E;
      4'hE: segOn = 7'h79;
      default: segOn = 7'h71;
    endcase
    return ~segOn;
  endfunction

endpackage

// File: rtl/key_sync.sv
// Multi-stage synchroniser for one asynchronous key level
module key_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic keyN,
  output logic keySyncN
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= {STAGES{IDLE}};
    else       pipe <= {pipe[STAGES-2:0], keyN};
  end

  assign keySyncN = pipe[STAGES-1];

endmodule

// File: rtl/press_ctrl.sv
// Control: synchronise both keys and turn falling edges into strobes
module press_ctrl
  import updown_key_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         incKeyN,
  input  logic         decKeyN,
  output ctrlStrobes_t strobes
);

  localparam int NUM_KEYS = 2;
  localparam int INC_IDX  = 0;
  localparam int DEC_IDX  = 1;

  logic [NUM_KEYS-1:0] rawN;
  logic [NUM_KEYS-1:0] syncN;
  logic [NUM_KEYS-1:0] prevN;
  logic [NUM_KEYS-1:0] fallDet;

  assign rawN[INC_IDX] = incKeyN;
  assign rawN[DEC_IDX] = decKeyN;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    key_sync #(
      .STAGES(SYNC_STAGES),
      .IDLE  (1'b1)
    ) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .keyN    (rawN[k]),
      .keySyncN(syncN[k])
    );

    // Previous level resets to released so reset never looks like a press
    always_ff @(posedge clk) begin
      if (!rstN) prevN[k] <= 1'b1;
      else       prevN[k] <= syncN[k];
    end

    assign fallDet[k] = prevN[k] & ~syncN[k];
  end

  assign strobes.incStb = fallDet[INC_IDX];
  assign strobes.decStb = fallDet[DEC_IDX];

endmodule

// File: rtl/count_dp.sv
// Datapath: wrapping counter plus segment decode
module count_dp
  import updown_key_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] count,
  output logic [6:0]       segN
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] countNext;

  always_comb begin
    unique case ({strobes.incStb, strobes.decStb})
      2'b10:   countNext = count + ONE;
      2'b01:   countNext = count - ONE;
      default: countNext = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= countNext;
  end

  assign segN = hexToSegN(count[3:0]);

endmodule

// File: rtl/updown_key_counter.sv
// Top: key controller and counter datapath
module updown_key_counter
  import updown_key_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incKeyN,
  input  logic             decKeyN,
  output logic [WIDTH-1:0] count,
  output logic [6:0]       segN
);

  ctrlStrobes_t strobes;

  press_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .incKeyN(incKeyN),
    .decKeyN(decKeyN),
    .strobes(strobes)
  );

  count_dp #(
    .WIDTH(WIDTH)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .count  (count),
    .segN   (segN)
  );

endmodule

// File: rtl/updown_key_counter_chk.sv
module updown_key_counter_chk
  import updown_key_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input ctrlStrobes_t     strobes,
  input logic [WIDTH-1:0] count
);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> count == '0);

  a_r2_inc_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incStb && !strobes.decStb) |=> count == WIDTH'($past(count) + 1'b1));

  a_r3_dec_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decStb && !strobes.incStb) |=> count == WIDTH'($past(count) - 1'b1));

  a_r6_both_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incStb && strobes.decStb) |=> $stable(count));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.incStb && !strobes.decStb) |=> $stable(count));

  a_r9_inc_single: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incStb |=> !strobes.incStb);

  a_r9_dec_single: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decStb |=> !strobes.decStb);

endmodule

bind updown_key_counter updown_key_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .strobes(strobes),
  .count  (count)
);

// File: tb/updown_key_counter_tb.sv
`timescale 1ns/1ps
module updown_key_counter_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       incKeyN;
  logic       decKeyN;
  logic [3:0] count;
  logic [6:0] segN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] expCount;
  logic       lastInc;
  logic       lastDec;

  always #4 clk = ~clk;

  updown_key_counter u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .incKeyN(incKeyN),
    .decKeyN(decKeyN),
    .count  (count),
    .segN   (segN)
  );

  function automatic logic [6:0] expSeg(input logic [3:0] v);
    logic [6:0] on;
    case (v)
      4'h0: on = 7'h3F; 4'h1: on = 7'h06; 4'h2: on = 7'h5B; 4'h3: on = 7'h4F;
      4'h4: on = 7'h66; 4'h5: on = 7'h6D; 4'h6: on = 7'h7D; 4'h7: on = 7'h07;
      4'h8: on = 7'h7F; 4'h9: on = 7'h6F; 4'hA: on = 7'h77; 4'hB: on = 7'h7C;
      4'hC: on = 7'h39; 4'hD: on = 7'h5E; 4'hE: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  function automatic logic [3:0] nextCount(input logic [3:0] c,
                                           input logic incFall,
                                           input logic decFall);
    if (incFall && !decFall) return c + 4'd1;
    if (decFall && !incFall) return c - 4'd1;
    return c;
  endfunction

  task automatic checkCount(input string req, input logic [3:0] exp);
    checks++;
    if (count !== exp) begin
      errors++;
      $display("FAIL %s count actual %0h expected %0h", req, count, exp);
    end
  endtask

  task automatic checkSeg(input string req);
    checks++;
    if (segN !== expSeg(count)) begin
      errors++;
      $display("FAIL %s segN actual %h expected %h", req, segN, expSeg(count));
    end
  endtask

  // Drive new key levels at a falling edge, let the pipeline settle, then check
  task automatic applyKeys(input logic incLvl, input logic decLvl, input string req);
    @(negedge clk);
    expCount = nextCount(expCount, lastInc & ~incLvl, lastDec & ~decLvl);
    incKeyN = incLvl;
    decKeyN = decLvl;
    lastInc = incLvl;
    lastDec = decLvl;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkCount(req, expCount);
    checkSeg("R8");
  endtask

  initial begin
    rstN = 1'b0; incKeyN = 1'b1; decKeyN = 1'b1;
    lastInc = 1'b1; lastDec = 1'b1; expCount = 4'd0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkCount("R1", 4'd0);
    checks++;
    if (segN !== 7'h40) begin
      errors++;
      $display("FAIL R1 segN actual %h expected 40", segN);
    end
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    checkCount("R1", 4'd0);

    // R7: latency through the two synchroniser flops
    incKeyN = 1'b0; lastInc = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkCount("R7", 4'd0);
    @(posedge clk);
    @(negedge clk);
    expCount = 4'd1;
    checkCount("R7", 4'd1);
    // R5: long hold gives one step
    repeat (20) @(posedge clk);
    @(negedge clk);
    checkCount("R5", 4'd1);
    applyKeys(1'b1, 1'b1, "R5");

    applyKeys(1'b0, 1'b1, "R2");
    applyKeys(1'b1, 1'b1, "R5");
    applyKeys(1'b1, 1'b0, "R3");
    applyKeys(1'b1, 1'b1, "R5");
    applyKeys(1'b1, 1'b0, "R3");
    applyKeys(1'b1, 1'b1, "R5");
    // R4: wrap below zero and back
    applyKeys(1'b1, 1'b0, "R4");
    checkCount("R4", 4'hF);
    applyKeys(1'b1, 1'b1, "R5");
    applyKeys(1'b0, 1'b1, "R4");
    checkCount("R4", 4'h0);
    applyKeys(1'b1, 1'b1, "R5");
    // R6: simultaneous presses
    applyKeys(1'b0, 1'b0, "R6");
    applyKeys(1'b1, 1'b1, "R6");

    // R8: walk through all 16 digits
    for (int i = 0; i < 16; i++) begin
      applyKeys(1'b0, 1'b1, "R2");
      applyKeys(1'b1, 1'b1, "R8");
    end

    // Random mix of key levels
    for (int i = 0; i < 400; i++) begin
      logic a;
      logic b;
      a = 1'($urandom);
      b = 1'($urandom);
      applyKeys(a, b, "R2/R3/R6");
    end

    // R1: reset mid-count clears it again
    @(negedge clk);
    incKeyN = 1'b1; decKeyN = 1'b1; rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expCount = 4'd0; lastInc = 1'b1; lastDec = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkCount("R1", 4'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule